// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block manages a bank of general-purpose pins, 12 by default or 8 when configured for the smaller variant. Software reaches it through a simple 32-bit register port. Each pin has three pieces of state: an output value, a direction bit that turns its output driver on, and a synchronized copy of its input. A single select register goes to an external pin multiplexer.

Every pin also has an interrupt detector, and software chooses its trigger condition per pin. Edge triggers latch a sticky status bit. Level triggers hold the status bit for as long as the level lasts. Status bits are qualified by a per-pin enable and a per-pin mask, and the qualified bits are ORed onto one interrupt line. Mask bits are set and cleared through two write-one registers. Status bits are acknowledged through a third one.

A register-driven soft reset holds the whole controller at its defaults while its bit is 1.

The register port is a write strobe with a byte address and write data. Read data is a combinational function of the address. Reads have no side effects. The reset input is assumed to be already synchronized to the clock.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A write to 0x18 sets the output values and a write to 0x20 sets the direction bits (1 = output driven). A write to 0x38 sets the multiplexer select bits. The ports follow these registers from the next cycle, and reads return only the low N bits; higher bits read 0.
- R2: Offset 0x1C reads each pin's input after a two-stage synchronizer. A change on a pin becomes visible on the second rising clock edge after it.
- R3: The trigger codes are 0 falling edge, 1 rising edge and 4 either edge. With the enable bit at 0x00 set, a detected edge sets that pin's status bit at 0x04. The bit stays set until it is acknowledged. An edge is judged on the synchronized input against its value one cycle earlier.
- R4: Code 2 (input low) and code 3 (input high) set the status bit on every cycle the level holds. An acknowledge in the same cycle does not clear it.
- R5: Writing a 1 to a bit of 0x0C clears that pin's status bit, and 0 bits have no effect. The register reads 0.
- R6: Writing a 1 to a bit of 0x10 masks that pin, and writing a 1 to a bit of 0x14 unmasks it. In both registers 0 bits have no effect. 0x10 reads the mask and 0x14 reads 0.
- R7: The interrupt output is the OR of status AND enable AND NOT mask over all pins. 0x08 reads that same per-pin vector.
- R8: Pin p below 8 keeps its 3-bit trigger code at bits [4p+2:4p] of 0x24. Pin p from 8 upward keeps it at bits [4(p-8)+2:4(p-8)] of 0x28. The fourth bit of each nibble reads 0. Codes 5 to 7 never set status.
- R9: Writing 1 to bit 0 of 0x3C resets every other register and all status bits, and holds them there. Writes to other registers are ignored until a write of 0 to 0x3C releases the block. Bit 0 of 0x3C reads back.
- R10: After reset every register reads 0, so all pins are inputs, disabled and unmasked. A pin whose enable bit is 0 never sets status. Writes to read-only offsets are ignored, and reserved offsets 0x2C to 0x34 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, synchronously released |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | N | Raw pin inputs |
| pin_out | output | N | Output values |
| pin_oe | output | N | Output enables (direction) |
| pin_alt | output | N | Multiplexer select bits |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is an acknowledge that lands on a cycle when a level trigger is still active. The same holds for an edge that arrives while the soft reset is being held. Reaching either requires a pin change, issued two cycles ahead, to line up with a register write. Directed phases set level modes and then acknowledge while the pin stays in its active state. A long pseudo-random phase then interleaves pin changes, mode rewrites, mask traffic and paired soft-reset writes. The bench tracks the reference model cycle by cycle, so every such coincidence is caught when it happens.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Trigger codes held per pin
  typedef enum logic [2:0] {
    TRG_FALL = 3'd0,
    TRG_RISE = 3'd1,
    TRG_LOW  = 3'd2,
    TRG_HIGH = 3'd3,
    TRG_BOTH = 3'd4
  } trig_e;

  // Word index (byte address bits [5:2]) of each register
  typedef enum logic [3:0] {
    RG_ENABLE = 4'h0,
    RG_STATUS = 4'h1,
    RG_VIEW   = 4'h2,
    RG_ACK    = 4'h3,
    RG_MSET   = 4'h4,
    RG_MCLR   = 4'h5,
    RG_DOUT   = 4'h6,
    RG_DIN    = 4'h7,
    RG_DIR    = 4'h8,
    RG_TRG_LO = 4'h9,
    RG_TRG_HI = 4'hA,
    RG_ALT    = 4'hE,
    RG_SRST   = 4'hF
  } reg_e;

  localparam int TRG_BITS    = 3;
  localparam int TRG_STRIDE  = 4;
  localparam int TRG_PER_REG = 8;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       lvl_i,
  input  logic       ack_i,
  input  logic       wipe_i,
  output logic       st_o
);

  trig_e mode_e;
  logic  prev_q;
  logic  st_q;
  logic  st_d;
  logic  cond;
  logic  hit;

  assign mode_e = trig_e'(mode_i);

  // Next-state: trigger condition, then sticky status with set priority
  always_comb begin
    case (mode_e)
      TRG_FALL: cond = ~lvl_i & prev_q;
      TRG_RISE: cond = lvl_i & ~prev_q;
      TRG_LOW:  cond = ~lvl_i;
      TRG_HIGH: cond = lvl_i;
      TRG_BOTH: cond = lvl_i ^ prev_q;
      default:  cond = 1'b0;
    endcase
    hit  = cond & en_i;
    st_d = wipe_i ? 1'b0 : ((st_q & ~ack_i) | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      st_q   <= st_d;
    end
  end

  assign st_o = st_q;

  // R3: a latched status bit only leaves through acknowledge or soft reset
  p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !ack_i && !wipe_i) |=> st_q);

  // R4: an active enabled level forces status on the next cycle
  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wipe_i && ((mode_i == TRG_HIGH && lvl_i) || (mode_i == TRG_LOW && !lvl_i)))
    |=> st_q);

  // R10: a disabled pin never raises its status
  p_no_set_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_q && !en_i) |=> !st_q);

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_irq_pkg::*;
#(
  parameter int N = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [3:0]           wr_idx_i,
  input  logic [31:0]          wr_data_i,
  output logic [N-1:0]         en_o,
  output logic [N-1:0]         mask_o,
  output logic [N-1:0]         dout_o,
  output logic [N-1:0]         dir_o,
  output logic [N-1:0]         alt_o,
  output logic [N-1:0][2:0]    mode_o,
  output logic                 srst_o,
  output logic [N-1:0]         ack_o
);

  localparam int LO_PINS = (N < TRG_PER_REG) ? N : TRG_PER_REG;

  logic [N-1:0]      en_q,   en_d;
  logic [N-1:0]      mask_q, mask_d;
  logic [N-1:0]      dout_q, dout_d;
  logic [N-1:0]      dir_q,  dir_d;
  logic [N-1:0]      alt_q,  alt_d;
  logic [N-1:0][2:0] mode_q, mode_d;
  logic              srst_q, srst_d;
  logic              ld;
  logic              unused_wdata;

  assign unused_wdata = ^wr_data_i;
  assign ld = srst_q | wr_en_i;

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    dout_d = dout_q;
    dir_d  = dir_q;
    alt_d  = alt_q;
    mode_d = mode_q;
    srst_d = srst_q;
    if (wr_en_i && wr_idx_i == RG_SRST) srst_d = wr_data_i[0];
    if (srst_q) begin
      en_d   = '0;
      mask_d = '0;
      dout_d = '0;
      dir_d  = '0;
      alt_d  = '0;
      mode_d = '0;
    end else if (wr_en_i) begin
      case (wr_idx_i)
        RG_ENABLE: en_d   = wr_data_i[N-1:0];
        RG_MSET:   mask_d = mask_q | wr_data_i[N-1:0];
        RG_MCLR:   mask_d = mask_q & ~wr_data_i[N-1:0];
        RG_DOUT:   dout_d = wr_data_i[N-1:0];
        RG_DIR:    dir_d  = wr_data_i[N-1:0];
        RG_ALT:    alt_d  = wr_data_i[N-1:0];
        RG_TRG_LO: begin
          for (int p = 0; p < LO_PINS; p++)
            mode_d[p] = wr_data_i[TRG_STRIDE*p +: TRG_BITS];
        end
        RG_TRG_HI: begin
          for (int p = TRG_PER_REG; p < N; p++)
            mode_d[p] = wr_data_i[TRG_STRIDE*(p-TRG_PER_REG) +: TRG_BITS];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      alt_q  <= '0;
      mode_q <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_d;
      if (ld) begin
        en_q   <= en_d;
        mask_q <= mask_d;
        dout_q <= dout_d;
        dir_q  <= dir_d;
        alt_q  <= alt_d;
        mode_q <= mode_d;
      end
    end
  end

  assign ack_o  = (wr_en_i && !srst_q && wr_idx_i == RG_ACK) ? wr_data_i[N-1:0] : '0;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign alt_o  = alt_q;
  assign mode_o = mode_q;
  assign srst_o = srst_q;

  // R9: while soft reset is held the configuration sits at its defaults
  p_srst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_q == '0 && mask_q == '0 && dout_q == '0 && dir_q == '0 && mode_q == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [5:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] pin_alt,
  output logic         irq
);

  localparam int LO_PINS = (N < TRG_PER_REG) ? N : TRG_PER_REG;

  logic [3:0]        idx;
  logic [N-1:0]      din;
  logic [N-1:0]      en;
  logic [N-1:0]      mask;
  logic [N-1:0]      alt;
  logic [N-1:0]      dout;
  logic [N-1:0]      dir;
  logic [N-1:0][2:0] mode;
  logic              srst;
  logic [N-1:0]      ack;
  logic [N-1:0]      st;
  logic [N-1:0]      view;
  logic [31:0]       trg_lo;
  logic [31:0]       trg_hi;
  logic              unused_addr;

  assign idx         = bus_addr[5:2];
  assign unused_addr = ^bus_addr[1:0];

  gpio_in_sync #(.W(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in),
    .q_o   (din)
  );

  gpio_regbank #(.N(N)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (bus_we),
    .wr_idx_i  (idx),
    .wr_data_i (bus_wdata),
    .en_o      (en),
    .mask_o    (mask),
    .dout_o    (dout),
    .dir_o     (dir),
    .alt_o     (alt),
    .mode_o    (mode),
    .srst_o    (srst),
    .ack_o     (ack)
  );

  for (genvar p = 0; p < N; p++) begin : g_pin
    gpio_trig_det u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en[p]),
      .mode_i (mode[p]),
      .lvl_i  (din[p]),
      .ack_i  (ack[p]),
      .wipe_i (srst),
      .st_o   (st[p])
    );
  end

  assign view    = st & en & ~mask;
  assign irq     = |view;
  assign pin_out = dout;
  assign pin_oe  = dir;
  assign pin_alt = alt;

  always_comb begin
    trg_lo = '0;
    trg_hi = '0;
    for (int p = 0; p < LO_PINS; p++)
      trg_lo[TRG_STRIDE*p +: TRG_BITS] = mode[p];
    for (int p = TRG_PER_REG; p < N; p++)
      trg_hi[TRG_STRIDE*(p-TRG_PER_REG) +: TRG_BITS] = mode[p];
  end

  always_comb begin
    case (idx)
      RG_ENABLE: bus_rdata = 32'(en);
      RG_STATUS: bus_rdata = 32'(st);
      RG_VIEW:   bus_rdata = 32'(view);
      RG_MSET:   bus_rdata = 32'(mask);
      RG_DOUT:   bus_rdata = 32'(dout);
      RG_DIN:    bus_rdata = 32'(din);
      RG_DIR:    bus_rdata = 32'(dir);
      RG_TRG_LO: bus_rdata = trg_lo;
      RG_TRG_HI: bus_rdata = trg_hi;
      RG_ALT:    bus_rdata = 32'(alt);
      RG_SRST:   bus_rdata = {31'd0, srst};
      default:   bus_rdata = '0;
    endcase
  end

  // R6: with every pin masked the line stays low
  p_full_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  // R7: the line is only raised by a latched status bit
  p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st != '0));

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [5:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [NP-1:0] pin_in;
  wire  [31:0]   bus_rdata;
  wire  [NP-1:0] pin_out;
  wire  [NP-1:0] pin_oe;
  wire  [NP-1:0] pin_alt;
  wire           irq;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.N(NP)) i_gpio_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_alt   (pin_alt),
    .irq       (irq)
  );

  // Reference model state
  logic [NP-1:0] m_en, m_st, m_mask, m_out, m_dir, m_alt, m_s1, m_s2, m_prev;
  logic [2:0]    m_mode [NP];
  logic          m_soft;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 1'b0;
  string         phase = "R10 reset defaults";

  function automatic logic trig(input logic [2:0] md, input logic cur, input logic old);
    case (md)
      3'd0:    return !cur && old;
      3'd1:    return cur && !old;
      3'd2:    return !cur;
      3'd3:    return cur;
      3'd4:    return cur != old;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    logic [31:0] v;
    v = '0;
    case (a[5:2])
      4'h0: v = 32'(m_en);
      4'h1: v = 32'(m_st);
      4'h2: v = 32'(m_st & m_en & ~m_mask);
      4'h4: v = 32'(m_mask);
      4'h6: v = 32'(m_out);
      4'h7: v = 32'(m_s2);
      4'h8: v = 32'(m_dir);
      4'h9: for (int p = 0; p < 8; p++) v[4*p +: 3] = m_mode[p];
      4'hA: for (int p = 8; p < NP; p++) v[4*(p-8) +: 3] = m_mode[p];
      4'hE: v = 32'(m_alt);
      4'hF: v = {31'd0, m_soft};
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a[5:2])
      4'h0:             return "R10 enable";
      4'h1:             return "R3 status";
      4'h2:             return "R7 view";
      4'h3:             return "R5 ack";
      4'h4, 4'h5:       return "R6 mask";
      4'h6, 4'h8, 4'hE: return "R1 register";
      4'h7:             return "R2 input";
      4'h9, 4'hA:       return "R8 mode";
      4'hF:             return "R9 soft reset";
      default:          return "R10 reserved";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // Model update at each edge, comparison a quarter period later
  always @(posedge clk) begin : mdl
    logic [NP-1:0] hit;
    logic [NP-1:0] ack;
    logic          was_soft;
    if (!rst_n) begin
      m_en = '0; m_st = '0; m_mask = '0; m_out = '0; m_dir = '0; m_alt = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_soft = 1'b0;
      for (int p = 0; p < NP; p++) m_mode[p] = '0;
    end else begin
      was_soft = m_soft;
      for (int p = 0; p < NP; p++) hit[p] = m_en[p] && trig(m_mode[p], m_s2[p], m_prev[p]);
      ack = (bus_we && bus_addr[5:2] == 4'h3 && !was_soft) ? bus_wdata[NP-1:0] : '0;
      if (was_soft) begin
        m_en = '0; m_st = '0; m_mask = '0; m_out = '0; m_dir = '0; m_alt = '0;
        for (int p = 0; p < NP; p++) m_mode[p] = '0;
      end else begin
        m_st = (m_st & ~ack) | hit;
        if (bus_we) begin
          case (bus_addr[5:2])
            4'h0: m_en   = bus_wdata[NP-1:0];
            4'h4: m_mask = m_mask | bus_wdata[NP-1:0];
            4'h5: m_mask = m_mask & ~bus_wdata[NP-1:0];
            4'h6: m_out  = bus_wdata[NP-1:0];
            4'h8: m_dir  = bus_wdata[NP-1:0];
            4'hE: m_alt  = bus_wdata[NP-1:0];
            4'h9: for (int p = 0; p < 8; p++) m_mode[p] = bus_wdata[4*p +: 3];
            4'hA: for (int p = 8; p < NP; p++) m_mode[p] = bus_wdata[4*(p-8) +: 3];
            default: ;
          endcase
        end
      end
      if (bus_we && bus_addr[5:2] == 4'hF) m_soft = bus_wdata[0];
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
    #5;
    if (!done) begin
      chk("R7 irq", 32'(irq), 32'(|(m_st & m_en & ~m_mask)));
      chk("R1 pin_out", 32'(pin_out), 32'(m_out));
      chk("R1 pin_oe", 32'(pin_oe), 32'(m_dir));
      chk("R1 pin_alt", 32'(pin_alt), 32'(m_alt));
      chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk);
    bus_addr = a;
  endtask

  task automatic pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired during [%s]", phase);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    idle(3);
    rst_n = 1'b1;

    phase = "R10 reset defaults";
    for (int a = 0; a < 16; a++) rd(6'(a * 4));

    phase = "R1 output direction select";
    wr(6'h18, 32'hFFFF_FFFF); idle(1);
    wr(6'h20, 32'hA5A5_5A5A); idle(1);
    wr(6'h38, 32'h0000_0F0F); idle(1);
    wr(6'h18, 32'h0000_03C3); idle(1);

    phase = "R2 input sync";
    rd(6'h1C);
    pins(12'hABC); idle(4);
    pins(12'h543); idle(1); pins(12'h000); idle(4);

    phase = "R8 mode fields";
    wr(6'h24, 32'hFFFF_FFFF); idle(1);
    wr(6'h28, 32'hFFFF_FFFF); idle(1);
    wr(6'h24, 32'h0154_3210); idle(1);
    wr(6'h28, 32'h0000_3401); idle(1);

    phase = "R3 edge detect";
    wr(6'h00, 32'h0000_0FFF);
    rd(6'h04);
    pins(12'hFFF); idle(5);
    pins(12'h000); idle(5);
    wr(6'h0C, 32'h0000_0FFF); rd(6'h04); idle(3);
    pins(12'h0F0); idle(4);

    phase = "R4 level hold";
    wr(6'h0C, 32'h0000_0004); rd(6'h04); idle(2);
    pins(12'h8F0); idle(4);
    wr(6'h0C, 32'h0000_0808); rd(6'h04); idle(3);

    phase = "R5 ack";
    wr(6'h0C, 32'h0000_0000); rd(6'h04); idle(1);
    wr(6'h0C, 32'h0000_0002); rd(6'h04); idle(1);
    wr(6'h0C, 32'h0000_0010); rd(6'h0C); idle(1);

    phase = "R6 R7 mask and irq";
    wr(6'h10, 32'h0000_0FFF); rd(6'h08); idle(2);
    wr(6'h14, 32'h0000_0004); rd(6'h10); idle(2);
    wr(6'h14, 32'h0000_0000); rd(6'h08); idle(1);
    wr(6'h14, 32'h0000_0FFF); rd(6'h14); idle(2);

    phase = "R10 enable gating";
    wr(6'h00, 32'h0000_0000);
    wr(6'h0C, 32'h0000_0FFF); rd(6'h04);
    pins(12'h0FF); idle(4); pins(12'hF00); idle(4);
    wr(6'h04, 32'h0000_0FFF); wr(6'h1C, 32'h0000_0FFF); wr(6'h30, 32'hFFFF_FFFF);
    rd(6'h30); rd(6'h2C); rd(6'h34); rd(6'h04);

    phase = "R9 soft reset";
    wr(6'h00, 32'h0000_0FFF); idle(3);
    wr(6'h3C, 32'h0000_0001); rd(6'h3C); idle(2);
    wr(6'h18, 32'h0000_0FFF); rd(6'h18);
    wr(6'h24, 32'h1111_1111); rd(6'h24);
    pins(12'h000); idle(3); rd(6'h04);
    wr(6'h3C, 32'h0000_0000); rd(6'h00); idle(2); rd(6'h04); idle(2);

    phase = "R3 R4 R7 random mix";
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[2:0])
        3'd0, 3'd1: pins(lf[19:8]);
        3'd2, 3'd3: begin
          if (lf[6:3] == 4'hF && lf[20]) begin
            wr(6'h3C, 32'h1); idle(1); wr(6'h3C, 32'h0);
          end else if (lf[6:3] != 4'hF) begin
            wr({lf[6:3], 2'b00}, {lf[12:0], lf[31:13]});
          end
        end
        3'd4: rd({lf[12:9], 2'b00});
        default: idle(1);
      endcase
    end
    idle(4);
    finish_run();
  end

endmodule